// File: doc/BRIEF.md
# Per-TDC Fragment Word Limiter

This block sits inline on a word stream that carries per-TDC fragments. A fragment opens with a begin word, carries a run of data words and closes with an end word. The block forwards at most a programmable number of data words per fragment and consumes the rest without emitting them. The begin and end words are always forwarded. When words were dropped, the block rewrites the word-count field of the end word so that it counts what actually left the block: the begin word, the kept data words and the end word.

Both stream sides use valid/ready handshakes. A single output register holds the outgoing word. The input is stalled whenever that register is full and the consumer is not taking it, so no word is lost. The limit lives in a small internal register that is loaded through a write strobe and comes out of reset at 96 data words. A truncated fragment has no effect on anything that follows it. Each new fragment starts with a fresh count.

Top module: `tdc_frag_limiter`

## Requirements
- R1: The limit register is 12 bits wide. A value from 1 to 4095 allows that many data words per fragment, and the value 0 allows 4096. The limit is loaded when `cfg_we` is high at a clock edge and is meant to change only between fragments.
- R2: Data words beyond the limit inside a fragment are consumed and not emitted. Begin and end words are always emitted unchanged in their tag and upper bits, in input order, one cycle after they are accepted.
- R3: When a fragment was truncated, bits [11:0] of its end word are replaced by (kept data words + 2) modulo 4096, and bits [31:12] are kept.
- R4: A fragment whose data word count is at or below the limit passes through with every word unchanged, including the original end word.
- R5: The word type comes from bits [31:28]: 0xA marks a begin word, 0xC marks an end word, and every other value marks a data word.
- R6: Every begin word restarts the data count and clears the truncation state, including a begin word that arrives without a preceding end word.
- R7: Truncating one fragment never suppresses or alters later fragments.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low, so no input word is lost.
- R9: After reset `out_valid` is 0, `in_ready` is 1 and the limit register holds 96 (0x060).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the limit register |
| cfg_limit | input | 12 | New limit value (0 means 4096) |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word, type tag in bits [31:28] |
| in_ready | output | 1 | Block can accept a word this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Consumer takes the output word this cycle |

## Verification
The bench instantiates the block with its default parameters: a 32-bit word, a 12-bit limit and a 4-bit tag. With those values the full limit range can be reached in a short run. That includes the 0 encoding, where a 4097-word fragment checks the 4096 cap and the wrap of the rewritten count field to 2. It also includes a limit of 4095 and the single-word limit. Table entries alternate between an always-ready consumer and a pseudo-random stalling consumer, so truncation and the count rewrite are both exercised under backpressure.

// File: rtl/tdc_frag_limiter.sv
module tdc_frag_limiter #(
  parameter int DATA_W = 32,
  parameter int LIMIT_W = 12,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] TAG_BEGIN = 4'hA,
  parameter logic [TAG_W-1:0] TAG_END = 4'hC,
  parameter logic [LIMIT_W-1:0] LIMIT_RESET = 12'h060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LIMIT_W-1:0] cfg_limit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int CNT_W = LIMIT_W + 1;
  localparam int TAG_LSB = DATA_W - TAG_W;

  logic [LIMIT_W-1:0] limit_q;
  logic [CNT_W-1:0]   kept_q;
  logic               cut_q;
  logic [CNT_W-1:0]   cap;
  logic [TAG_W-1:0]   tag;
  logic               is_bot, is_eot, room, take, emit;
  logic [LIMIT_W-1:0] fixed_cnt;
  logic [DATA_W-1:0]  patched;

  assign tag       = in_data[DATA_W-1:TAG_LSB];
  assign is_bot    = (tag == TAG_BEGIN);
  assign is_eot    = (tag == TAG_END);
  assign cap       = (limit_q == '0) ? (CNT_W'(1) << LIMIT_W) : {1'b0, limit_q};
  assign room      = (kept_q < cap);
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;
  assign emit      = is_bot || is_eot || room;
  assign fixed_cnt = LIMIT_W'(kept_q + CNT_W'(2));
  assign patched   = (is_eot && cut_q) ? {in_data[DATA_W-1:LIMIT_W], fixed_cnt} : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= LIMIT_RESET;
    else if (cfg_we) limit_q <= cfg_limit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kept_q <= '0;
      cut_q  <= 1'b0;
    end else if (take) begin
      if (is_bot || is_eot) begin
        kept_q <= '0;
        cut_q  <= 1'b0;
      end else if (room) begin
        kept_q <= kept_q + CNT_W'(1);
      end else begin
        cut_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= emit;
      out_data  <= patched;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  logic [CNT_W-1:0] seen_q;
  logic [TAG_W-1:0] out_tag;
  logic             out_fire;
  assign out_tag  = out_data[DATA_W-1:TAG_LSB];
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (out_fire) begin
      if (out_tag == TAG_BEGIN || out_tag == TAG_END) seen_q <= '0;
      else seen_q <= seen_q + CNT_W'(1);
    end
  end

  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n || cfg_we)
    out_fire && out_tag != TAG_BEGIN && out_tag != TAG_END |-> seen_q < cap);

  assert_bot_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_bot |=> out_valid && out_data == $past(in_data));

  assert_eot_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_eot |=> out_valid && out_data[DATA_W-1:LIMIT_W] == $past(in_data[DATA_W-1:LIMIT_W]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_tdc_frag_limiter.sv
module tb_tdc_frag_limiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_limit = '0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid;
  logic [31:0] out_data;
  logic out_ready = 1'b1;

  always #4 clk = ~clk;

  tdc_frag_limiter dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_limit(cfg_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  int n_chk = 0, n_fail = 0;
  logic [31:0] expw [0:4299];
  logic [31:0] got  [0:4299];
  int ecnt = 0, gcnt = 0;
  logic stall = 1'b0, hold = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  localparam int NV = 8;
  localparam int TL [NV] = '{4, 4, 4, 4, 1, 1, 4095, 96};
  localparam int TN [NV] = '{3, 4, 5, 20, 0, 2, 10, 200};
  localparam bit TS [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = hold ? 1'b0 : (stall ? (lfsr[0] | lfsr[2]) : 1'b1);
  end

  always begin
    @(negedge clk); #3;
    if (out_valid && out_ready && gcnt < 4300) begin
      got[gcnt] = out_data;
      gcnt++;
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic int eff(input int l);
    return (l == 0) ? 4096 : l;
  endfunction

  function automatic logic [31:0] dword(input int id, input int i);
    logic [3:0] t;
    case (i % 5) 0: t = 4'h3; 1: t = 4'h0; 2: t = 4'hF; 3: t = 4'hB; default: t = 4'h5; endcase
    return {t, 12'(id), 16'(i)};
  endfunction

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic setlim(input int l);
    @(negedge clk); cfg_we = 1'b1; cfg_limit = 12'(l);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send_frag(input int id, input int n, input logic [11:0] orig);
    put({4'hA, 16'(id), 12'h000});
    for (int i = 0; i < n; i++) put(dword(id, i));
    put({4'hC, 16'(id), orig});
  endtask

  task automatic model_frag(input int id, input int n, input int lim, input logic [11:0] orig);
    int k;
    k = (n < eff(lim)) ? n : eff(lim);
    expw[ecnt] = {4'hA, 16'(id), 12'h000}; ecnt++;
    for (int i = 0; i < k; i++) begin expw[ecnt] = dword(id, i); ecnt++; end
    expw[ecnt] = {4'hC, 16'(id), (n > eff(lim)) ? 12'(k + 2) : orig}; ecnt++;
  endtask

  task automatic compare(input string req);
    int bad;
    repeat (40) @(negedge clk);
    n_chk++;
    bad = -1;
    for (int i = 0; i < ecnt; i++) if (bad < 0 && i < gcnt && got[i] !== expw[i]) bad = i;
    if (gcnt != ecnt) begin
      n_fail++;
      $display("FAIL %s: word count actual %0d expected %0d", req, gcnt, ecnt);
    end else if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: word %0d actual %h expected %h", req, bad, got[bad], expw[bad]);
    end
    gcnt = 0; ecnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: reset state valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end

    // R9: default limit of 96
    model_frag(1, 100, 96, 12'(102));
    send_frag(1, 100, 12'(102));
    compare("R9 default limit");

    // table: R2 R3 R4 R5 R7 across limits and consumer stalls
    for (int v = 0; v < NV; v++) begin
      stall = TS[v];
      setlim(TL[v]);
      model_frag(10 + v, TN[v], TL[v], 12'(TN[v] + 2));
      send_frag(10 + v, TN[v], 12'(TN[v] + 2));
      compare("R2 R3 R5 R7 table");
    end
    stall = 1'b0;

    // R1: zero encodes 4096, count field wraps to 2
    setlim(0);
    model_frag(30, 4097, 0, 12'(4099));
    send_frag(30, 4097, 12'(4099));
    compare("R1 zero limit");

    // R4: untruncated end word passes with its odd count field
    setlim(3);
    model_frag(31, 3, 3, 12'hABC);
    send_frag(31, 3, 12'hABC);
    compare("R4 end unchanged");

    // R6: begin without end restarts count
    setlim(4);
    expw[0] = {4'hA, 16'd32, 12'h000};
    for (int i = 0; i < 3; i++) expw[1 + i] = dword(32, i);
    expw[4] = {4'hA, 16'd33, 12'h000};
    for (int i = 0; i < 4; i++) expw[5 + i] = dword(33, i);
    expw[9] = {4'hC, 16'd33, 12'd6};
    ecnt = 10;
    put({4'hA, 16'd32, 12'h000});
    for (int i = 0; i < 3; i++) put(dword(32, i));
    send_frag(33, 5, 12'd7);
    compare("R6 orphan begin");

    // R8: held output under a blocked consumer
    hold = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = {4'hA, 16'd40, 12'h000};
    @(negedge clk);
    in_data = dword(40, 0);
    repeat (4) @(negedge clk);
    #2;
    n_chk++;
    if (out_valid !== 1'b1 || out_data !== {4'hA, 16'd40, 12'h000}) begin
      n_fail++;
      $display("FAIL R8: held word %h valid %b expected %h 1", out_data, out_valid, {4'hA, 16'd40, 12'h000});
    end
    n_chk++;
    if (in_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: in_ready actual %b expected 0", in_ready);
    end
    @(negedge clk);
    hold = 1'b0;
    #1;
    @(posedge clk); #1 in_valid = 1'b0;
    put({4'hC, 16'd40, 12'd3});
    expw[0] = {4'hA, 16'd40, 12'h000};
    expw[1] = dword(40, 0);
    expw[2] = {4'hC, 16'd40, 12'd3};
    ecnt = 3;
    compare("R8 no loss under stall");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule